// File: doc/BRIEF.md
# Phase Core for Direct Digital Synthesis

This block produces the phase stream that drives a sine lookup in a direct digital synthesizer. Each clock it adds an active frequency tuning word to a 32-bit phase accumulator, takes the upper 14 bits of that accumulator, adds a 14-bit phase offset, and registers the result as the output phase word. The output frequency is the tuning word times the clock rate divided by 2^32. A phase offset of (degrees/360) × 2^14 shifts every sample by that angle, so 45 degrees is 2048.

Software-facing logic writes new tuning and offset values into staging registers with a write pulse. These staged values do nothing until a one-cycle commit pulse copies both into the active registers. When the restart control is high during a commit, the accumulator is also zeroed, so the new tone begins at a known phase of 0 degrees plus the new offset.

Top module: `dds_phase_core`

## Requirements
- R1: While reset is high and on the first cycle after it, phase_out is 0. Reset clears the accumulator, both staging registers and both active registers.
- R2: Each clock edge with no restart, the accumulator gains the active tuning word. phase_out after an edge equals the accumulator's upper 14 bits (bits 31..18) as held before that edge, plus the active offset as held before that edge.
- R3: A write to a staging register (tune_wr or offs_wr high) without a commit leaves phase_out unchanged from what the old active values give.
- R4: A commit (commit_stb high for one cycle) copies both staging registers into the active registers at that edge. The accumulator uses the new tuning word from the following edge on.
- R5: A commit with restart_en high loads 0 into the accumulator at that edge. From the next edge on, the accumulator adds the newly active tuning word.
- R6: A commit with restart_en low does not disturb the accumulator. At that edge it still adds the tuning word that was active before.
- R7: The 14-bit offset sum wraps modulo 2^14.
- R8: The accumulator wraps modulo 2^32.
- R9: When a write and a commit happen in the same cycle, the commit moves the value staged before that cycle. The newly written value stays staged for the next commit.
- R10: restart_en high without a commit has no effect on the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_wr | input | 1 | Loads tune_in into the staging tuning register |
| tune_in | input | 32 | New frequency tuning word |
| offs_wr | input | 1 | Loads offs_in into the staging offset register |
| offs_in | input | 14 | New phase offset word |
| commit_stb | input | 1 | One-cycle pulse moving staged values into the active registers |
| restart_en | input | 1 | When high during a commit, zeroes the accumulator |
| phase_out | output | 14 | Registered output phase word |

## Verification
A corrupted accumulator shows up at phase_out one edge later, because the output register is the only stage between the accumulator and the port. The error then persists, because the accumulator never forgets an offset. A wrong active tuning word bends the phase slope in the second cycle after the commit. A missed restart shows as a nonzero base phase straight after the commit. Staging errors stay hidden until the next commit. For that reason the sequence commits again after each staging corner, including a write that coincides with a commit.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int unsigned DEF_ACC_W = 32;
  localparam int unsigned DEF_OFF_W = 14;

  // Decoded commit action for one cycle.
  typedef struct packed {
    logic load;     // active registers take the staged values
    logic zero;     // accumulator restarts from zero
  } commit_t;

  function automatic commit_t decode_commit(input logic stb, input logic restart);
    commit_t c;
    c.load = stb;
    c.zero = stb & restart;
    return c;
  endfunction

endpackage

// File: rtl/dds_stage_reg.sv
// Double-buffered register: a staging copy written by software-side logic,
// and an active copy refreshed only on commit.
module dds_stage_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         load,
  output logic [W-1:0] staged_q,
  output logic [W-1:0] active_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= '0;
    end else if (wr) begin
      staged_q <= din;
    end
  end

  // Commit reads the staged value from before this edge (write-then-commit
  // in one cycle promotes the older value).
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (load) begin
      active_q <= staged_q;
    end
  end

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] acc_next;

  always_comb begin
    if (zero) begin
      acc_next = '0;
    end else begin
      acc_next = acc_q + step;   // modulo 2^ACC_W by width
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_next;
    end
  end

endmodule

// File: rtl/dds_phase_map.sv
// Truncates the accumulator and applies the phase offset, registered.
module dds_phase_map #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OFF_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc,
  input  logic [OFF_W-1:0] offs,
  output logic [OFF_W-1:0] phase_q
);

  localparam int unsigned TOP_LSB = ACC_W - OFF_W;

  logic [OFF_W-1:0] coarse;
  logic [OFF_W-1:0] sum;

  generate
    if (TOP_LSB == 0) begin : g_full
      assign coarse = acc;
    end else begin : g_trunc
      assign coarse = acc[ACC_W-1:TOP_LSB];
    end
  endgenerate

  assign sum = coarse + offs;   // modulo 2^OFF_W by width

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else begin
      phase_q <= sum;
    end
  end

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W = DEF_ACC_W,
  parameter int unsigned OFF_W = DEF_OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tune_wr,
  input  logic [ACC_W-1:0] tune_in,
  input  logic             offs_wr,
  input  logic [OFF_W-1:0] offs_in,
  input  logic             commit_stb,
  input  logic             restart_en,
  output logic [OFF_W-1:0] phase_out
);

  commit_t          commit;
  logic [ACC_W-1:0] tune_staged;
  logic [ACC_W-1:0] tune_active;
  logic [OFF_W-1:0] offs_staged;
  logic [OFF_W-1:0] offs_active;
  logic [ACC_W-1:0] acc_q;

  assign commit = decode_commit(commit_stb, restart_en);

  dds_stage_reg #(.W(ACC_W)) u_tune_reg (
    .clk      (clk),
    .rst      (rst),
    .wr       (tune_wr),
    .din      (tune_in),
    .load     (commit.load),
    .staged_q (tune_staged),
    .active_q (tune_active)
  );

  dds_stage_reg #(.W(OFF_W)) u_offs_reg (
    .clk      (clk),
    .rst      (rst),
    .wr       (offs_wr),
    .din      (offs_in),
    .load     (commit.load),
    .staged_q (offs_staged),
    .active_q (offs_active)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .zero  (commit.zero),
    .step  (tune_active),
    .acc_q (acc_q)
  );

  dds_phase_map #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_map (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc_q),
    .offs    (offs_active),
    .phase_q (phase_out)
  );

endmodule

// File: rtl/dds_phase_core_chk.sv
module dds_phase_core_chk #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OFF_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             commit_stb,
  input logic             restart_en,
  input logic [ACC_W-1:0] tune_staged,
  input logic [ACC_W-1:0] tune_active,
  input logic [OFF_W-1:0] offs_staged,
  input logic [OFF_W-1:0] offs_active,
  input logic [ACC_W-1:0] acc_q,
  input logic [OFF_W-1:0] phase_out
);

  localparam int unsigned TOP_LSB = ACC_W - OFF_W;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (phase_out == '0 && acc_q == '0)); // R1

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    !(commit_stb && restart_en) |=> acc_q == $past(acc_q + tune_active)); // R2

  AST_OUT_MAP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_out == $past(acc_q[ACC_W-1:TOP_LSB] + offs_active)); // R7

  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !commit_stb |=> ($stable(tune_active) && $stable(offs_active))); // R3

  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    commit_stb |=> (tune_active == $past(tune_staged) && offs_active == $past(offs_staged))); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && restart_en) |=> acc_q == '0); // R5

endmodule

bind dds_phase_core dds_phase_core_chk #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .commit_stb  (commit_stb),
  .restart_en  (restart_en),
  .tune_staged (tune_staged),
  .tune_active (tune_active),
  .offs_staged (offs_staged),
  .offs_active (offs_active),
  .acc_q       (acc_q),
  .phase_out   (phase_out)
);

// File: tb/test_dds_phase_core.sv
`timescale 1ns/1ps
module test_dds_phase_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tune_wr = 1'b0;
  logic [31:0] tune_in = '0;
  logic        offs_wr = 1'b0;
  logic [13:0] offs_in = '0;
  logic        commit_stb = 1'b0;
  logic        restart_en = 1'b0;
  logic [13:0] phase_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_acc = '0, m_tact = '0, m_tstg = '0;
  logic [13:0] m_oact = '0, m_ostg = '0;

  logic [13:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dds_phase_core i_dds_phase_core (
    .clk(clk), .rst(rst), .tune_wr(tune_wr), .tune_in(tune_in),
    .offs_wr(offs_wr), .offs_in(offs_in), .commit_stb(commit_stb),
    .restart_en(restart_en), .phase_out(phase_out)
  );

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: phase_out actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected output.
  task automatic step(input logic tw, input logic [31:0] td, input logic ow,
                      input logic [13:0] od, input logic cs, input logic re,
                      input string tag);
    logic [13:0] out_n;
    logic [31:0] acc_n, tact_n, tstg_n;
    logic [13:0] oact_n, ostg_n;
    tune_wr = tw; tune_in = td; offs_wr = ow; offs_in = od;
    commit_stb = cs; restart_en = re;
    @(posedge clk);
    #1;
    out_n  = m_acc[31:18] + m_oact;
    acc_n  = (cs && re) ? 32'd0 : m_acc + m_tact;
    tact_n = cs ? m_tstg : m_tact;
    oact_n = cs ? m_ostg : m_oact;
    tstg_n = tw ? td : m_tstg;
    ostg_n = ow ? od : m_ostg;
    m_acc = acc_n; m_tact = tact_n; m_oact = oact_n; m_tstg = tstg_n; m_ostg = ostg_n;
    exp_q.push_back(out_n);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, 0, tag);
  endtask

  // Monitor: compares each produced sample against the scoreboard.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), phase_out, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", phase_out, 14'd0);          // during reset
    rst = 1'b0;
    idle(3, "R1");                           // nothing active yet

    // R3: staged write without commit
    step(1, 32'h4E147AE1, 1, 14'd2048, 0, 0, "R3");
    idle(4, "R3");

    // R4: commit without restart, then run
    step(0, '0, 0, '0, 1, 0, "R4");
    idle(12, "R4");

    // R6: new tune staged, commit without restart keeps phase
    step(1, 32'h27611340, 0, '0, 0, 0, "R6");
    step(0, '0, 0, '0, 1, 0, "R6");
    idle(6, "R6");

    // R10: restart_en alone
    step(0, '0, 0, '0, 0, 1, "R10");
    step(0, '0, 0, '0, 0, 1, "R10");
    idle(3, "R10");

    // R5: commit with restart, new offset 45 deg
    step(0, '0, 1, 14'd2048, 0, 0, "R5");
    step(0, '0, 0, '0, 1, 1, "R5");
    idle(8, "R5");

    // R7 and R8: large tune and offset near full scale
    step(1, 32'hF0000001, 1, 14'h3FFF, 0, 0, "R8");
    step(0, '0, 0, '0, 1, 1, "R8");
    idle(40, "R8");
    step(0, '0, 1, 14'h3F00, 1, 0, "R7");
    idle(20, "R7");

    // R9: write and commit in the same cycle
    step(1, 32'h0001A36F, 1, 14'd100, 1, 1, "R9");
    idle(5, "R9");
    step(0, '0, 0, '0, 1, 1, "R9");
    idle(10, "R9");

    // R2: plain accumulation with a small tune
    step(1, 32'h00040000, 1, 14'd0, 1, 1, "R2");
    step(0, '0, 0, '0, 1, 1, "R2");
    idle(10, "R2");

    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    exp_q.delete(); tag_q.delete();
    check("R1", phase_out, 14'd0);
    rst = 1'b0;
    m_acc = '0; m_tact = '0; m_tstg = '0; m_oact = '0; m_ostg = '0;
    step(0, '0, 0, '0, 1, 0, "R1");          // commit staged zeros
    idle(4, "R1");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule